// File: doc/BRIEF.md
# Gap-Free Symbol Stream Packer

The block accepts a stream of 128-bit beats, each carrying sixteen 8-bit symbol lanes, and packs the valid symbols of every beat back to back into one wide message register. Every beat comes with an empty count, and the packer applies it on every beat, not only on the last beat of a packet. A beat with `e` empty lanes contributes its `16 - e` lowest lanes. The packer writes them into the next free symbol slots, so partial beats anywhere in the stream close up with no holes between them.

A write pointer counts filled slots in symbol units. When the pointer reaches the end of the message (1600 symbols, 12,800 bits), the packer does three things: it pulses a done flag for one cycle, raises a full level, and presents the finished message in parallel. While the message is full, the packer drops `in_ready` and ignores the stream. An acknowledge input releases it so that the next message can begin.

If a beat carries more symbols than the message has room for, the packer stores only the symbols that fit and discards the rest. In that case it also sets a sticky overflow flag.

The stream input uses valid/ready rules. A beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while a completed message is being held. The source must keep its beat on the bus until the beat is accepted. The packer never stalls for any other reason.

Top module: `stream_packer`

## Requirements
- R1: A synchronous active-high reset clears the write pointer, every message bit, `msg_full`, `msg_done` and `msg_overflow`, and leaves `in_ready` high.
- R2: An accepted beat carries `16 - in_empty` valid symbols, held in the low-order lanes: lane `j` is `in_data[8j+7:8j]`. A beat with `in_empty` of 16 or more carries zero symbols and does not move the pointer.
- R3: Message slot `k` is `msg_data[8k+7:8k]`. An accepted beat with `n` valid symbols writes lane `j` into slot `pointer + j` for `j < n`, then advances the pointer by `n`. The first beat after reset starts at slot 0.
- R4: A cycle with `in_valid` low changes neither the message nor the pointer.
- R5: `msg_done` is high for exactly one cycle, in the first cycle after the edge where the pointer reaches 1600. `msg_full` rises in that same cycle.
- R6: While `msg_full` is high, `in_ready` is low, and the message and pointer stay unchanged whatever the input does.
- R7: `msg_ack` high while `msg_full` is high returns the pointer to slot 0 and clears `msg_full` and `msg_overflow` on that edge.
- R8: If a beat holds more valid symbols than the slots left, only the lowest lanes that fit are stored. The message completes as in R5, and `msg_overflow` is set and stays set until R7 or reset.
- R9: `msg_ack` while `msg_full` is low has no effect: the next beat continues at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat present on `in_data`/`in_empty` |
| in_ready | output | 1 | Packer can take a beat (low while full) |
| in_data | input | 128 | Sixteen 8-bit lanes, lane 0 lowest |
| in_empty | input | 5 | Number of unused high lanes in the beat |
| msg_ack | input | 1 | Releases a completed message |
| msg_done | output | 1 | One-cycle pulse on message completion |
| msg_full | output | 1 | Completed message held on `msg_data` |
| msg_overflow | output | 1 | Sticky: symbols were discarded at the end of the message |
| msg_data | output | 12800 | Packed message, slot k at bits 8k+7:8k |

## Verification
A pointer that is off by even one slot appears on `msg_data` on the very next accepted beat: the new symbols land shifted, leaving either a hole or an overwritten slot. The bench therefore compares the whole message after every beat. A wrong fill count shows up as `msg_done` and `msg_full` arriving a beat early or late, or as overflow being flagged when it should not be, and the bench checks those flags in the cycle right after the filling edge. A packer that leaks input while holding a message changes `msg_data` within one cycle of an ignored beat.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // Number of symbols a beat carries, from its empty count.
  function automatic int unsigned beat_symbols(input int unsigned empty_cnt,
                                               input int unsigned lanes);
    return (empty_cnt >= lanes) ? 0 : (lanes - empty_cnt);
  endfunction

endpackage

// File: rtl/sp_beat_count.sv
module sp_beat_count #(
  parameter int LANES   = 16,
  parameter int EMPTY_W = 5,
  parameter int CNT_W   = 5
) (
  input  logic [EMPTY_W-1:0] empty_cnt,
  output logic [CNT_W-1:0]   sym_cnt
);
  import sp_pkg::*;

  always_comb begin
    sym_cnt = CNT_W'(beat_symbols(int'(empty_cnt), LANES));
  end

endmodule

// File: rtl/sp_write_ctrl.sv
module sp_write_ctrl #(
  parameter int MSG_SYMS = 1600,
  parameter int PTR_W    = 11,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] sym_cnt,
  input  logic             ack,
  output logic             ready,
  output logic             accept,
  output logic [PTR_W-1:0] ptr,
  output logic [CNT_W-1:0] wr_cnt,
  output logic             full,
  output logic             done,
  output logic             overflow
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(MSG_SYMS);

  logic [PTR_W-1:0] room;
  logic [PTR_W-1:0] cnt_ext;
  logic [PTR_W-1:0] ptr_next;
  logic             spill;

  always_comb begin
    ready    = !full;
    accept   = in_valid && ready;
    room     = LAST - ptr;
    cnt_ext  = PTR_W'(sym_cnt);
    spill    = cnt_ext > room;
    wr_cnt   = spill ? CNT_W'(room) : sym_cnt;
    ptr_next = ptr + PTR_W'(wr_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      full     <= 1'b0;
      done     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      done <= 1'b0;
      if (full && ack) begin
        ptr      <= '0;
        full     <= 1'b0;
        overflow <= 1'b0;
      end else if (accept) begin
        ptr <= ptr_next;
        if (spill) overflow <= 1'b1;
        if (ptr_next == LAST) begin
          full <= 1'b1;
          done <= 1'b1;
        end
      end
    end
  end

  // R3
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> ptr == $past(ptr) + PTR_W'($past(wr_cnt)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid && !(full && ack) |=> $stable(ptr) && $stable(overflow));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  done_full_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> full && ptr == LAST);
  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full && !ack |=> full && $stable(ptr));
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    full && ack |=> ptr == '0 && !full && !overflow);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow && !(full && ack) |=> overflow);

endmodule

// File: rtl/sp_slot_bank.sv
module sp_slot_bank #(
  parameter int SYM_W    = 8,
  parameter int LANES    = 16,
  parameter int MSG_SYMS = 1600,
  parameter int PTR_W    = 11,
  parameter int CNT_W    = 5,
  parameter int LANE_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      accept,
  input  logic [PTR_W-1:0]          ptr,
  input  logic [CNT_W-1:0]          wr_cnt,
  input  logic [SYM_W*LANES-1:0]    data,
  output logic [SYM_W*MSG_SYMS-1:0] msg
);
  logic [PTR_W:0] limit;
  assign limit = {1'b0, PTR_W'(wr_cnt)};

  for (genvar k = 0; k < MSG_SYMS; k++) begin : g_slot
    localparam logic [PTR_W:0] KPOS = (PTR_W+1)'(k);
    logic [PTR_W:0]     off;
    logic               load;
    logic [LANE_W-1:0]  lane;
    logic [SYM_W-1:0]   q;

    // Offset is negative (top bit set) for slots below the pointer.
    assign off  = KPOS - {1'b0, ptr};
    assign load = accept && !off[PTR_W] && (off < limit);
    assign lane = off[LANE_W-1:0];

    always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= data[lane*SYM_W +: SYM_W];
    end

    assign msg[k*SYM_W +: SYM_W] = q;
  end

  // R4 R6
  msg_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(msg));

endmodule

// File: rtl/stream_packer.sv
module stream_packer #(
  parameter int SYM_W    = 8,
  parameter int LANES    = 16,
  parameter int MSG_SYMS = 1600,
  localparam int DATA_W  = SYM_W * LANES,
  localparam int EMPTY_W = $clog2(LANES) + 1,
  localparam int MSG_W   = SYM_W * MSG_SYMS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic               msg_ack,
  output logic               msg_done,
  output logic               msg_full,
  output logic               msg_overflow,
  output logic [MSG_W-1:0]   msg_data
);
  localparam int PTR_W  = $clog2(MSG_SYMS + 1);
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int LANE_W = $clog2(LANES);

  logic [CNT_W-1:0] sym_cnt;
  logic [CNT_W-1:0] wr_cnt;
  logic [PTR_W-1:0] ptr;
  logic             accept;

  sp_beat_count #(.LANES(LANES), .EMPTY_W(EMPTY_W), .CNT_W(CNT_W)) cnt_i (
    .empty_cnt (in_empty),
    .sym_cnt   (sym_cnt)
  );

  sp_write_ctrl #(.MSG_SYMS(MSG_SYMS), .PTR_W(PTR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .sym_cnt  (sym_cnt),
    .ack      (msg_ack),
    .ready    (in_ready),
    .accept   (accept),
    .ptr      (ptr),
    .wr_cnt   (wr_cnt),
    .full     (msg_full),
    .done     (msg_done),
    .overflow (msg_overflow)
  );

  sp_slot_bank #(
    .SYM_W(SYM_W), .LANES(LANES), .MSG_SYMS(MSG_SYMS),
    .PTR_W(PTR_W), .CNT_W(CNT_W), .LANE_W(LANE_W)
  ) bank_i (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .ptr    (ptr),
    .wr_cnt (wr_cnt),
    .data   (in_data),
    .msg    (msg_data)
  );

  // R6
  full_ready_chk: assert property (@(posedge clk) disable iff (rst)
    msg_full && !msg_ack |=> !in_ready && $stable(msg_data));

endmodule

// File: tb/stream_packer_tb_top.sv
module stream_packer_tb_top;
  localparam int SYMS  = 1600;
  localparam int LN    = 16;
  localparam int MSG_W = SYMS * 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic             in_ready;
  logic [127:0]     in_data;
  logic [4:0]       in_empty;
  logic             msg_ack;
  logic             msg_done;
  logic             msg_full;
  logic             msg_overflow;
  logic [MSG_W-1:0] msg_data;

  always #2 clk = ~clk;

  stream_packer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_empty(in_empty), .msg_ack(msg_ack),
    .msg_done(msg_done), .msg_full(msg_full), .msg_overflow(msg_overflow),
    .msg_data(msg_data)
  );

  int checks = 0;
  int failures = 0;

  // Reference model
  logic [MSG_W-1:0] e_msg;
  int  m_ptr;
  bit  m_full, m_ovf, e_done;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    int bad;
    bad = -1;
    for (int k = 0; k < SYMS; k++)
      if (bad < 0 && msg_data[k*8 +: 8] !== e_msg[k*8 +: 8]) bad = k;
    chk(bad < 0, req, $sformatf("message slot %0d", bad < 0 ? 0 : bad),
        bad < 0 ? 0 : longint'(msg_data[bad*8 +: 8]),
        bad < 0 ? 0 : longint'(e_msg[bad*8 +: 8]));
    chk(in_ready === !m_full, req, "in_ready", longint'(in_ready), longint'(!m_full));
    chk(msg_full === m_full, req, "msg_full", longint'(msg_full), longint'(m_full));
    chk(msg_done === e_done, req, "msg_done", longint'(msg_done), longint'(e_done));
    chk(msg_overflow === m_ovf, req, "msg_overflow", longint'(msg_overflow), longint'(m_ovf));
  endtask

  task automatic beat(input bit v, input logic [127:0] d, input logic [4:0] e,
                      input string req);
    int n, w;
    @(negedge clk);
    in_valid = v; in_data = d; in_empty = e;
    e_done = 0;
    if (v && !m_full) begin
      n = (e >= LN) ? 0 : LN - int'(e);
      w = (n > SYMS - m_ptr) ? SYMS - m_ptr : n;
      for (int j = 0; j < w; j++) e_msg[(m_ptr + j)*8 +: 8] = d[j*8 +: 8];
      if (n > w) m_ovf = 1;
      m_ptr += w;
      if (m_ptr == SYMS) begin m_full = 1; e_done = 1; end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    check_all(req);
  endtask

  task automatic ack(input string req);
    @(negedge clk);
    msg_ack = 1'b1;
    e_done = 0;
    if (m_full) begin m_ptr = 0; m_full = 0; m_ovf = 0; end
    @(posedge clk); #1;
    msg_ack = 1'b0;
    check_all(req);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic fill_to(input int target, input string req);
    int n;
    while (m_ptr < target) begin
      if ($urandom % 8 == 0) begin
        beat(1, rnd128(), 5'(16 + $urandom % 16), req);
      end else begin
        n = 1 + $urandom % 16;
        if (n > target - m_ptr) n = target - m_ptr;
        beat(1, rnd128(), 5'(16 - n), req);
      end
    end
  endtask

  task automatic t_reset();
    rst = 1; in_valid = 0; in_data = '0; in_empty = '0; msg_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    e_msg = '0; m_ptr = 0; m_full = 0; m_ovf = 0; e_done = 0;
    #1;
    check_all("R1");
  endtask

  task automatic t_example();
    beat(1, {120'h0, 8'hA1} | {8'hEE, 120'h0}, 5'd15, "R2");
    beat(1, {112'hDEAD, 16'hB2B1}, 5'd14, "R3");
    chk(msg_data[31:0] === 32'h00B2B1A1, "R3", "first slots",
        longint'(msg_data[31:0]), 64'hB2B1A1);
  endtask

  task automatic t_ignore();
    beat(0, rnd128(), 5'd0, "R4");
    beat(1, rnd128(), 5'd16, "R2");
    beat(1, rnd128(), 5'd31, "R2");
    beat(1, rnd128(), 5'd13, "R2");
    beat(1, rnd128(), 5'd0, "R3");
  endtask

  task automatic t_ack_idle();
    ack("R9");
    beat(1, rnd128(), 5'd9, "R9");
  endtask

  task automatic t_fill();
    fill_to(SYMS, "R5");
    chk(msg_done === 1'b1, "R5", "done after fill", longint'(msg_done), 1);
    beat(0, rnd128(), 5'd0, "R5");
  endtask

  task automatic t_hold();
    beat(1, rnd128(), 5'd0, "R6");
    beat(1, rnd128(), 5'd12, "R6");
    beat(0, rnd128(), 5'd0, "R6");
  endtask

  task automatic t_ack();
    ack("R7");
    beat(1, rnd128(), 5'd11, "R7");
    chk(msg_data[39:0] === in_data[39:0], "R7", "restart at slot 0",
        longint'(msg_data[39:0]), longint'(in_data[39:0]));
  endtask

  task automatic t_overflow();
    fill_to(SYMS - 5, "R8");
    beat(1, rnd128(), 5'd0, "R8");
    beat(1, rnd128(), 5'd0, "R8");
    ack("R8");
    chk(msg_overflow === 1'b0, "R8", "overflow cleared by ack", longint'(msg_overflow), 0);
  endtask

  initial begin
    t_reset();
    t_example();
    t_ignore();
    t_ack_idle();
    t_fill();
    t_hold();
    t_ack();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule